// File: doc/BRIEF.md
# Dual-Read Single-Write Register File with Zero Register

This block holds the general-purpose registers of a small processor datapath. It has sixteen words of sixteen bits. Two independent read ports return register contents combinationally from their select inputs. A single gated write port updates one register at the rising clock edge, so one instruction can fetch two source operands and retire a result within the same cycle.

Register 0 is a constant zero source. It is not backed by storage, and writes aimed at it are discarded. A synchronous clear input empties the whole file in one cycle and takes precedence over any write presented with it. An asynchronous active-low reset, released in step with the clock, also brings every register to zero. No bypass path exists: a read of the register being written in the same cycle still returns the old contents.

Top module: `gpr_file`

## Requirements
- R1: After reset is released, every register reads as 0x0000 on both read ports.
- R2: With `wr_en`=1, `clr`=0 and `wr_sel`≠0, the value on `wr_data` appears on any read port selecting `wr_sel` after the next rising clock edge.
- R3: With `wr_en`=0 and `clr`=0, no register changes at a clock edge, whatever `wr_sel` and `wr_data` carry.
- R4: The two read ports are independent and combinational: each returns the register named by its own 4-bit select in the same cycle, and both may select the same register or different ones.
- R5: Select value 0 on a read port always returns 0x0000, and a write with `wr_sel`=0 changes no register.
- R6: With `clr`=1 at a rising edge, every register reads 0x0000 afterwards.
- R7: When `clr`=1 and `wr_en`=1 together, the clear wins and the addressed register also becomes 0x0000.
- R8: During the cycle in which a register is being written, a read of it returns its previous contents; the new value shows only after the edge.
- R9: A write changes only the register named by `wr_sel`; all others keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of every register |
| wr_en | input | 1 | Write enable for the write port |
| wr_sel | input | 4 | Destination register number |
| wr_data | input | 16 | Value to write |
| rd_sel_a | input | 4 | Register number for read port A |
| rd_data_a | output | 16 | Contents of the register selected on port A |
| rd_sel_b | input | 4 | Register number for read port B |
| rd_data_b | output | 16 | Contents of the register selected on port B |

## Verification
The clocked properties assume `clr`, `wr_en`, `wr_sel` and `wr_data` are stable and known around each rising edge, and that reset is held low from time zero until the clock runs. The bench changes every input only on the falling edge and asserts reset before the first edge, so each property samples settled values. Read selects may change at any time, since the read paths hold no state.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned NUM_REGS = 16;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned SEL_W    = $clog2(NUM_REGS);
endpackage

// File: rtl/gpr_rst_sync.sv
module gpr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int unsigned NUM_REGS = gpr_pkg::NUM_REGS,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  output logic [NUM_REGS-1:0] we_vec
);
  // Slot 0 never receives a strobe: the zero register has no storage.
  assign we_vec[0] = 1'b0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_dec
    assign we_vec[g] = wr_en && (wr_sel == SEL_W'(g));
  end

  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));

  assert_no_zero_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel == '0) |-> (we_vec == '0));
endmodule

// File: rtl/gpr_cell.sv
module gpr_cell #(
  parameter int unsigned DATA_W = gpr_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic              load;
  logic [DATA_W-1:0] q_nxt;

  // Clear outranks the write strobe.
  always_comb begin
    load  = clr || we;
    q_nxt = clr ? '0 : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= q_nxt;
  end

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && we) |=> (q == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && we) |=> (q == $past(d)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !we) |=> $stable(q));
endmodule

// File: rtl/gpr_rd_mux.sv
module gpr_rd_mux #(
  parameter int unsigned NUM_REGS = gpr_pkg::NUM_REGS,
  parameter int unsigned DATA_W   = gpr_pkg::DATA_W,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [SEL_W-1:0]                sel,
  output logic [DATA_W-1:0]               data
);
  always_comb begin
    data = regs_i[sel];
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int unsigned NUM_REGS = gpr_pkg::NUM_REGS,
  parameter int unsigned DATA_W   = gpr_pkg::DATA_W,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [SEL_W-1:0]  rd_sel_b,
  output logic [DATA_W-1:0] rd_data_b
);
  logic                            rst_sync_n;
  logic [NUM_REGS-1:0]             we_vec;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  gpr_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  gpr_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (wr_en),
    .wr_sel(wr_sel),
    .we_vec(we_vec)
  );

  // Entry 0 is a constant; only entries 1..NUM_REGS-1 hold flops.
  assign regs[0] = '0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    gpr_cell #(.DATA_W(DATA_W)) u_cell (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .clr  (clr),
      .we   (we_vec[g]),
      .d    (wr_data),
      .q    (regs[g])
    );
  end

  gpr_rd_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_a (
    .regs_i(regs),
    .sel   (rd_sel_a),
    .data  (rd_data_a)
  );

  gpr_rd_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_b (
    .regs_i(regs),
    .sel   (rd_sel_b),
    .data  (rd_data_b)
  );

  assert_zero_port_a_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_sel_a == '0) |-> (rd_data_a == '0));

  assert_zero_port_b_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_sel_b == '0) |-> (rd_data_b == '0));

  assert_same_sel_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_sel_a == rd_sel_b) |-> (rd_data_a == rd_data_b));
endmodule

// File: tb/gpr_file_tb_top.sv
module gpr_file_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr;
  logic        wr_en;
  logic [3:0]  wr_sel;
  logic [15:0] wr_data;
  logic [3:0]  rd_sel_a;
  logic [15:0] rd_data_a;
  logic [3:0]  rd_sel_b;
  logic [15:0] rd_data_b;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpr_file dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a),
    .rd_sel_b(rd_sel_b), .rd_data_b(rd_data_b)
  );

  typedef struct packed {
    logic        clr;
    logic        we;
    logic [3:0]  wsel;
    logic [15:0] wdata;
    logic [3:0]  sa;
    logic [3:0]  sb;
    logic [15:0] exp_a;
    logic [15:0] exp_b;
  } vec_t;

  // Reads are checked before the edge that applies the row's write/clear.
  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 4'd0,  16'h0000, 4'd1,  4'd2,  16'h0000, 16'h0000}, // R1
    '{1'b0, 1'b1, 4'd1,  16'h1234, 4'd1,  4'd0,  16'h0000, 16'h0000}, // R8
    '{1'b0, 1'b1, 4'd2,  16'hBEEF, 4'd1,  4'd2,  16'h1234, 16'h0000}, // R2
    '{1'b0, 1'b1, 4'd0,  16'hFFFF, 4'd2,  4'd1,  16'hBEEF, 16'h1234}, // R4
    '{1'b0, 1'b0, 4'd3,  16'h5555, 4'd0,  4'd2,  16'h0000, 16'hBEEF}, // R5
    '{1'b0, 1'b0, 4'd0,  16'h0000, 4'd3,  4'd0,  16'h0000, 16'h0000}, // R3
    '{1'b0, 1'b1, 4'd15, 16'hA5A5, 4'd15, 4'd15, 16'h0000, 16'h0000}, // R8
    '{1'b1, 1'b1, 4'd1,  16'h7777, 4'd15, 4'd1,  16'hA5A5, 16'h1234}, // R7
    '{1'b0, 1'b0, 4'd0,  16'h0000, 4'd1,  4'd15, 16'h0000, 16'h0000}, // R6
    '{1'b0, 1'b1, 4'd2,  16'h0001, 4'd2,  4'd2,  16'h0000, 16'h0000}, // R2
    '{1'b0, 1'b0, 4'd0,  16'h0000, 4'd2,  4'd1,  16'h0001, 16'h0000}  // R9
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic w, input logic [3:0] ws,
                       input logic [15:0] wd, input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    clr = c; wr_en = w; wr_sel = ws; wr_data = wd; rd_sel_a = a; rd_sel_b = b;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    rd_sel_a = '0; rd_sel_b = '0;
    do_reset();

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].clr, VECS[i].we, VECS[i].wsel, VECS[i].wdata, VECS[i].sa, VECS[i].sb);
      chk($sformatf("vec%0d port A", i), rd_data_a, VECS[i].exp_a);
      chk($sformatf("vec%0d port B", i), rd_data_b, VECS[i].exp_b);
    end

    // R9/R4: fill every register, then read all pairs
    for (int r = 0; r < 16; r++) begin
      drive(1'b0, 1'b1, 4'(r), 16'(r * 16'h1111), 4'd0, 4'd0);
    end
    drive(1'b0, 1'b0, 4'd0, 16'h0000, 4'd0, 4'd0);
    for (int a = 0; a < 16; a++) begin
      int b;
      b = 15 - a;
      drive(1'b0, 1'b0, 4'd0, 16'h0000, 4'(a), 4'(b));
      chk("R9/R4 fill port A", rd_data_a, (a == 0) ? 16'h0000 : 16'(a * 16'h1111));
      chk("R9/R4 fill port B", rd_data_b, (b == 0) ? 16'h0000 : 16'(b * 16'h1111));
    end

    // R3: disabled write with busy inputs changes nothing
    drive(1'b0, 1'b0, 4'd6, 16'hDEAD, 4'd6, 4'd7);
    drive(1'b0, 1'b0, 4'd7, 16'hCAFE, 4'd6, 4'd7);
    chk("R3 hold reg6", rd_data_a, 16'h6666);
    chk("R3 hold reg7", rd_data_b, 16'h7777);

    // R5: write to 0 leaves everything intact
    drive(1'b0, 1'b1, 4'd0, 16'h9999, 4'd0, 4'd9);
    drive(1'b0, 1'b0, 4'd0, 16'h0000, 4'd0, 4'd9);
    chk("R5 zero reg", rd_data_a, 16'h0000);
    chk("R5 reg9 intact", rd_data_b, 16'h9999);

    // R1: asynchronous reset mid-run clears the file
    do_reset();
    drive(1'b0, 1'b0, 4'd0, 16'h0000, 4'd5, 4'd14);
    chk("R1 reset reg5", rd_data_a, 16'h0000);
    chk("R1 reset reg14", rd_data_b, 16'h0000);

    // R6/R7 at the top index
    drive(1'b0, 1'b1, 4'd15, 16'h0F0F, 4'd15, 4'd0);
    drive(1'b1, 1'b1, 4'd15, 16'hF0F0, 4'd15, 4'd0);
    chk("R2 reg15 loaded", rd_data_a, 16'h0F0F);
    drive(1'b0, 1'b0, 4'd0, 16'h0000, 4'd15, 4'd0);
    chk("R7 clear over write", rd_data_a, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule